// File: doc/BRIEF.md
# Oldest-First Instruction Issue Queue

This block holds the tags of dispatched instructions until they can run, and sends them to execution oldest first. Each tag is a wrap-around sequence index. A tag lives in one of a fixed number of slots. A slot is free, waiting (operands outstanding), ready (operands present, not yet sent) or executing (sent, result not yet written back). A dispatch places a tag either in the waiting state or straight in the ready state, depending on its operand flag. A wakeup naming the tag's index later promotes a waiting entry to ready.

Every cycle, the ready entry with the oldest index is offered as the issue candidate. It is sent out in that same cycle if the execution resource grants it. An issued tag stays in its slot, in the executing state, until a writeback naming its index frees the slot. A dispatch may carry an immediate-issue flag. Such an instruction has its operands and finds the resource free. If no queued entry is ready, it goes out in its dispatch cycle and enters the executing state directly. Dispatch stalls while every slot is occupied.

Age is judged modulo the index range. Index a is older than index b when the top bit of (a − b), taken in the index width, is set. The indices in flight must therefore span less than half the range.

Top module: `issue_queue`

## Requirements
- R1: After reset all slots are free, disp_ready_o is 1 and issue_valid_o is 0.
- R2: A dispatch with disp_opnd_rdy_i = 0 creates a waiting entry, which is never issued before a wakeup names its index. A dispatched index must not match any occupied slot.
- R3: A wakeup (wake_valid_i = 1) naming a waiting entry in cycle t makes it issuable from cycle t+1, not in cycle t. A wakeup naming a free, ready or executing index has no effect.
- R4: When at least one entry is ready and res_rdy_i = 1, issue_valid_o is 1 in that cycle. issue_idx_o is then the oldest ready index, where a is older than b when bit SEQ_W−1 of (a − b) is 1. At most one tag issues per cycle, and nothing issues while res_rdy_i = 0.
- R5: An issued entry is not issued again. It holds its slot until a writeback carries its index. In that cycle wb_done_o is 1, and the slot is free from the next cycle on.
- R6: A writeback whose index is not held by an executing entry gives wb_done_o = 0 and changes no entry.
- R7: An accepted dispatch with disp_imm_i = 1, disp_opnd_rdy_i = 1 and res_rdy_i = 1, in a cycle with no ready entry, drives issue_valid_o = 1 with issue_idx_o = disp_idx_i in that cycle and enters the executing state. If a queued ready entry exists, or res_rdy_i = 0, the dispatch goes to the ready state instead.
- R8: disp_ready_o is 0 exactly when all NUM_SLOTS slots are occupied. A dispatch while disp_ready_o is 0 is ignored. A writeback that frees a slot makes disp_ready_o 1 in the following cycle.
- R9: A non-immediate dispatch with disp_opnd_rdy_i = 1 becomes ready at the next edge. It cannot issue in its own dispatch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_idx_i | input | SEQ_W | Sequence index of the dispatched tag |
| disp_opnd_rdy_i | input | 1 | Operands of the dispatched tag are available |
| disp_imm_i | input | 1 | Dispatched tag asks for issue in its dispatch cycle |
| disp_ready_o | output | 1 | At least one slot is free |
| wake_valid_i | input | 1 | Operand wakeup |
| wake_idx_i | input | SEQ_W | Index whose operands became available |
| res_rdy_i | input | 1 | Execution resource grants the candidate this cycle |
| issue_valid_o | output | 1 | A tag is issued this cycle |
| issue_idx_o | output | SEQ_W | Index of the issued tag |
| wb_valid_i | input | 1 | Writeback completion |
| wb_idx_i | input | SEQ_W | Index reaching writeback |
| wb_done_o | output | 1 | Writeback matched an executing entry |

## Verification
An immediate-issue dispatch and a queued ready entry can compete for the single issue port in the same cycle. The bench provokes this by dispatching an immediate tag while an older tag sits ready, and again with no ready tag present. It expects the queued tag to win in the first case and the new tag to go out in its own cycle in the second. Wakeup, issue, writeback and dispatch also land in the same cycles under random stimulus. A reference model updates its per-index states in requirement order and is compared each cycle, including across index wrap-around.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } slot_state_e;

    // a is older than b when bit (w-1) of (a - b) is set (modulo 2**w)
    function automatic logic wrap_older(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input int unsigned  w);
        logic [31:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/iq_slot.sv
module iq_slot
    import iq_pkg::*;
#(
    parameter int SEQ_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_i,
    input  logic [SEQ_W-1:0] alloc_idx_i,
    input  slot_state_e      alloc_state_i,
    input  logic             wake_valid_i,
    input  logic [SEQ_W-1:0] wake_idx_i,
    input  logic             issue_i,
    input  logic             wb_valid_i,
    input  logic [SEQ_W-1:0] wb_idx_i,
    output slot_state_e      state_o,
    output logic [SEQ_W-1:0] idx_o,
    output logic             wb_hit_o
);

    slot_state_e      state_q, state_d;
    logic [SEQ_W-1:0] idx_q;
    logic             wake_hit;

    assign wake_hit = wake_valid_i && (state_q == ST_WAIT) && (wake_idx_i == idx_q);
    assign wb_hit_o = wb_valid_i && (state_q == ST_EXEC) && (wb_idx_i == idx_q);

    always_comb begin
        state_d = state_q;
        if (alloc_i) begin
            state_d = alloc_state_i;
        end else begin
            unique case (state_q)
                ST_WAIT:  if (wake_hit) state_d = ST_READY;
                ST_READY: if (issue_i)  state_d = ST_EXEC;
                ST_EXEC:  if (wb_hit_o) state_d = ST_FREE;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (alloc_i) idx_q <= alloc_idx_i;
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

    p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> state_q == ST_FREE)
        else $error("allocation into occupied slot");

    p_wait_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !(wake_valid_i && wake_idx_i == idx_q)) |=> state_q == ST_WAIT)
        else $error("waiting entry left without wakeup");

    p_issue_ready_r4: assert property (@(posedge clk) disable iff (rst)
        issue_i |-> state_q == ST_READY)
        else $error("issue of non-ready slot");

    p_exec_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && !(wb_valid_i && wb_idx_i == idx_q)) |=> state_q == ST_EXEC)
        else $error("executing entry left without writeback");

    p_free_stays_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FREE && !alloc_i) |=> state_q == ST_FREE)
        else $error("free slot occupied without dispatch");

endmodule

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0] occupied_i,
    output logic                 any_free_o,
    output logic [NUM_SLOTS-1:0] grant_o
);

    // lowest-numbered free slot wins
    always_comb begin
        grant_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!occupied_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    assign any_free_o = ~&occupied_i;

endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick
    import iq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SEQ_W     = 5
) (
    input  logic [NUM_SLOTS-1:0]            ready_i,
    input  logic [NUM_SLOTS-1:0][SEQ_W-1:0] idx_i,
    output logic                            valid_o,
    output logic [NUM_SLOTS-1:0]            sel_o,
    output logic [SEQ_W-1:0]                idx_o
);

    localparam int PAD_W = 32 - SEQ_W;

    always_comb begin
        valid_o = 1'b0;
        sel_o   = '0;
        idx_o   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ready_i[i] &&
                (!valid_o || wrap_older({{PAD_W{1'b0}}, idx_i[i]},
                                        {{PAD_W{1'b0}}, idx_o}, SEQ_W))) begin
                valid_o  = 1'b1;
                sel_o    = '0;
                sel_o[i] = 1'b1;
                idx_o    = idx_i[i];
            end
        end
    end

endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SEQ_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_valid_i,
    input  logic [SEQ_W-1:0] disp_idx_i,
    input  logic             disp_opnd_rdy_i,
    input  logic             disp_imm_i,
    output logic             disp_ready_o,
    input  logic             wake_valid_i,
    input  logic [SEQ_W-1:0] wake_idx_i,
    input  logic             res_rdy_i,
    output logic             issue_valid_o,
    output logic [SEQ_W-1:0] issue_idx_o,
    input  logic             wb_valid_i,
    input  logic [SEQ_W-1:0] wb_idx_i,
    output logic             wb_done_o
);

    localparam int PAD_W = 32 - SEQ_W;

    slot_state_e                     slot_state [NUM_SLOTS];
    logic [NUM_SLOTS-1:0][SEQ_W-1:0] slot_idx;
    logic [NUM_SLOTS-1:0]            occupied, ready_vec, wb_hit, dup_hit;
    logic [NUM_SLOTS-1:0]            free_grant, cand_sel, issue_sel;
    logic                            any_free, cand_valid;
    logic [SEQ_W-1:0]                cand_idx;
    logic                            disp_fire, q_issue, imm_issue;
    slot_state_e                     alloc_state;

    iq_free_pick #(.NUM_SLOTS(NUM_SLOTS)) i_free (
        .occupied_i (occupied),
        .any_free_o (any_free),
        .grant_o    (free_grant)
    );

    iq_age_pick #(.NUM_SLOTS(NUM_SLOTS), .SEQ_W(SEQ_W)) i_age (
        .ready_i (ready_vec),
        .idx_i   (slot_idx),
        .valid_o (cand_valid),
        .sel_o   (cand_sel),
        .idx_o   (cand_idx)
    );

    assign disp_fire = disp_valid_i && any_free;
    assign q_issue   = cand_valid && res_rdy_i;
    assign imm_issue = disp_fire && disp_imm_i && disp_opnd_rdy_i && res_rdy_i && !cand_valid;
    assign issue_sel = q_issue ? cand_sel : '0;

    always_comb begin
        if (imm_issue)            alloc_state = ST_EXEC;
        else if (disp_opnd_rdy_i) alloc_state = ST_READY;
        else                      alloc_state = ST_WAIT;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        iq_slot #(.SEQ_W(SEQ_W)) i_slot (
            .clk           (clk),
            .rst           (rst),
            .alloc_i       (disp_fire && free_grant[g]),
            .alloc_idx_i   (disp_idx_i),
            .alloc_state_i (alloc_state),
            .wake_valid_i  (wake_valid_i),
            .wake_idx_i    (wake_idx_i),
            .issue_i       (issue_sel[g]),
            .wb_valid_i    (wb_valid_i),
            .wb_idx_i      (wb_idx_i),
            .state_o       (slot_state[g]),
            .idx_o         (slot_idx[g]),
            .wb_hit_o      (wb_hit[g])
        );
        assign occupied[g]  = slot_state[g] != ST_FREE;
        assign ready_vec[g] = slot_state[g] == ST_READY;
        assign dup_hit[g]   = occupied[g] && (slot_idx[g] == disp_idx_i);

        p_oldest_r4: assert property (@(posedge clk) disable iff (rst)
            (issue_valid_o && ready_vec[g] && !issue_sel[g]) |->
                wrap_older({{PAD_W{1'b0}}, issue_idx_o},
                           {{PAD_W{1'b0}}, slot_idx[g]}, SEQ_W))
            else $error("younger ready tag issued ahead of an older one");
    end

    assign disp_ready_o  = any_free;
    assign issue_valid_o = q_issue || imm_issue;
    assign issue_idx_o   = q_issue ? cand_idx : disp_idx_i;
    assign wb_done_o     = |wb_hit;

    p_unique_dispatch_r2: assert property (@(posedge clk) disable iff (rst)
        disp_fire |-> !(|dup_hit))
        else $error("dispatched index already held");

    p_one_issue_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_sel))
        else $error("more than one slot issued");

    p_res_gate_r7: assert property (@(posedge clk) disable iff (rst)
        issue_valid_o |-> res_rdy_i)
        else $error("issue without resource grant");

    p_single_wb_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_hit))
        else $error("writeback matched several slots");

endmodule

// File: tb/test_issue_queue.sv
module test_issue_queue;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int SW         = 5;
    localparam int RANGE      = 1 << SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          disp_valid = 0, disp_opnd = 0, disp_imm = 0;
    logic [SW-1:0] disp_idx = '0;
    logic          wake_valid = 0;
    logic [SW-1:0] wake_idx = '0;
    logic          res_rdy = 0;
    logic          wb_valid = 0;
    logic [SW-1:0] wb_idx = '0;
    logic          disp_ready, issue_valid, wb_done;
    logic [SW-1:0] issue_idx;

    int checks = 0, fails = 0;
    bit finished = 0;
    int st [RANGE];            // 0 free, 1 waiting, 2 ready, 3 executing
    bit got_dr, got_iv, got_wd;
    int got_idx;
    int next_seq = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    issue_queue #(.NUM_SLOTS(N), .SEQ_W(SW)) i_issue_queue (
        .clk(clk), .rst(rst),
        .disp_valid_i(disp_valid), .disp_idx_i(disp_idx),
        .disp_opnd_rdy_i(disp_opnd), .disp_imm_i(disp_imm),
        .disp_ready_o(disp_ready),
        .wake_valid_i(wake_valid), .wake_idx_i(wake_idx),
        .res_rdy_i(res_rdy),
        .issue_valid_o(issue_valid), .issue_idx_o(issue_idx),
        .wb_valid_i(wb_valid), .wb_idx_i(wb_idx),
        .wb_done_o(wb_done)
    );

    function automatic bit older(input int a, input int b);
        int d;
        d = (a - b) & (RANGE - 1);
        return d >= RANGE / 2;
    endfunction

    function automatic int live_count();
        int c = 0;
        for (int j = 0; j < RANGE; j++) if (st[j] != 0) c++;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cycle(input bit dv, input int di, input bit dop, input bit dim,
                             input bit kv, input int ki, input bit rr,
                             input bit wv, input int wi);
        bit exp_dr, fire, cand_v, exp_iv, exp_wd, imm;
        int cand, exp_idx;
        disp_valid = dv; disp_idx = SW'(di); disp_opnd = dop; disp_imm = dim;
        wake_valid = kv; wake_idx = SW'(ki); res_rdy = rr;
        wb_valid = wv; wb_idx = SW'(wi);
        #2;
        exp_dr = live_count() < N;
        fire   = dv && exp_dr;
        cand_v = 0; cand = 0;
        for (int j = 0; j < RANGE; j++)
            if (st[j] == 2 && (!cand_v || older(j, cand))) begin cand_v = 1; cand = j; end
        imm     = fire && dim && dop && rr && !cand_v;
        exp_iv  = (cand_v && rr) || imm;
        exp_idx = (cand_v && rr) ? cand : di;
        exp_wd  = wv && st[wi] == 3;
        got_dr = disp_ready; got_iv = issue_valid; got_wd = wb_done; got_idx = int'(issue_idx);
        check(got_dr == exp_dr, "R8 disp_ready", got_dr, exp_dr);
        check(got_iv == exp_iv, "R4 issue_valid", got_iv, exp_iv);
        if (exp_iv && got_iv) check(got_idx == exp_idx, "R4 issue_idx", got_idx, exp_idx);
        check(got_wd == exp_wd, "R5 wb_done", got_wd, exp_wd);
        @(posedge clk);
        if (exp_wd) st[wi] = 0;
        if (kv && st[ki] == 1) st[ki] = 2;
        if (cand_v && rr) st[cand] = 3;
        if (fire) st[di] = imm ? 3 : (dop ? 2 : 1);
        @(negedge clk);
    endtask

    task automatic idle(input bit rr);
        run_cycle(0, 0, 0, 0, 0, 0, rr, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int j = 0; j < RANGE; j++) st[j] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        idle(1);
        check(got_dr == 1, "R1 disp_ready after reset", got_dr, 1);
        check(got_iv == 0, "R1 no issue after reset", got_iv, 0);

        // R2: waiting entry stays until woken
        run_cycle(1, 0, 0, 0, 0, 0, 1, 0, 0);
        idle(1);
        check(got_iv == 0, "R2 waiting entry not issued", got_iv, 0);
        // R3: wakeup not usable in its own cycle
        run_cycle(0, 0, 0, 0, 1, 0, 1, 0, 0);
        check(got_iv == 0, "R3 no issue in wakeup cycle", got_iv, 0);
        idle(1);
        check(got_iv == 1 && got_idx == 0, "R3 issue after wakeup", got_idx, 0);
        // R6: writeback of absent index ignored
        run_cycle(0, 0, 0, 0, 0, 0, 1, 1, 5);
        check(got_wd == 0, "R6 stray writeback", got_wd, 0);
        // R3: wakeup of an executing entry ignored
        run_cycle(0, 0, 0, 0, 1, 0, 1, 0, 0);
        check(got_iv == 0, "R3 wakeup of executing entry", got_iv, 0);
        // R5: writeback frees entry
        run_cycle(0, 0, 0, 0, 0, 0, 1, 1, 0);
        check(got_wd == 1, "R5 writeback matched", got_wd, 1);
        run_cycle(0, 0, 0, 0, 0, 0, 1, 1, 0);
        check(got_wd == 0, "R5 entry already gone", got_wd, 0);

        // R9: ready dispatch not issued in its own cycle
        run_cycle(1, 1, 1, 0, 0, 0, 1, 0, 0);
        check(got_iv == 0, "R9 no issue in dispatch cycle", got_iv, 0);
        // R7: immediate dispatch loses to queued ready entry
        run_cycle(1, 2, 1, 1, 0, 0, 1, 0, 0);
        check(got_iv == 1 && got_idx == 1, "R7 queued entry wins", got_idx, 1);
        idle(1);
        check(got_iv == 1 && got_idx == 2, "R7 losing immediate issued from ready", got_idx, 2);
        // R7: immediate issue in dispatch cycle
        run_cycle(1, 3, 1, 1, 0, 0, 1, 0, 0);
        check(got_iv == 1 && got_idx == 3, "R7 immediate issue", got_idx, 3);
        // R7: no grant -> goes to ready
        run_cycle(1, 4, 1, 1, 0, 0, 0, 0, 0);
        check(got_iv == 0, "R7 immediate without grant", got_iv, 0);
        idle(1);
        check(got_iv == 1 && got_idx == 4, "R7 later issue from ready", got_idx, 4);
        for (int k = 1; k <= 4; k++) run_cycle(0, 0, 0, 0, 0, 0, 0, 1, k);

        // R8: fill all slots with waiting entries
        for (int k = 5; k < 5 + N; k++) run_cycle(1, k, 0, 0, 0, 0, 0, 0, 0);
        run_cycle(1, 13, 1, 0, 0, 0, 1, 0, 0);
        check(got_dr == 0, "R8 full stalls dispatch", got_dr, 0);
        check(got_iv == 0, "R8 ignored dispatch not issued", got_iv, 0);
        // R4: wake out of order, expect oldest first
        run_cycle(0, 0, 0, 0, 1, 12, 0, 0, 0);
        run_cycle(0, 0, 0, 0, 1, 9, 0, 0, 0);
        run_cycle(0, 0, 0, 0, 1, 7, 0, 0, 0);
        idle(1);
        check(got_idx == 7, "R4 oldest first", got_idx, 7);
        idle(1);
        check(got_idx == 9, "R4 second oldest", got_idx, 9);
        idle(1);
        check(got_idx == 12, "R4 third oldest", got_idx, 12);
        run_cycle(0, 0, 0, 0, 0, 0, 0, 1, 7);
        idle(0);
        check(got_dr == 1, "R8 space after writeback", got_dr, 1);
        next_seq = 13;

        // random phase: wraps the index range many times
        for (int c = 0; c < 4000; c++) begin
            bit dv, ok, kv, wv;
            int ki, wi, s;
            ok = st[next_seq] == 0;
            for (int j = 0; j < RANGE; j++)
                if (st[j] != 0 && ((next_seq - j) & (RANGE - 1)) >= 12) ok = 0;
            dv = ok && ($urandom % 4 != 0);
            kv = $urandom % 3 != 0;
            ki = $urandom % RANGE;
            if ($urandom % 4 != 0) begin
                s = $urandom % RANGE;
                for (int j = 0; j < RANGE; j++)
                    if (st[(s + j) % RANGE] == 1) begin ki = (s + j) % RANGE; break; end
            end
            wv = $urandom % 3 != 0;
            wi = $urandom % RANGE;
            if ($urandom % 4 != 0) begin
                s = $urandom % RANGE;
                for (int j = 0; j < RANGE; j++)
                    if (st[(s + j) % RANGE] == 3) begin wi = (s + j) % RANGE; break; end
            end
            if (dv && live_count() < N) begin
                run_cycle(1, next_seq, bit'($urandom % 2), bit'($urandom % 2), kv, ki,
                          bit'($urandom % 4 != 0), wv, wi);
                next_seq = (next_seq + 1) % RANGE;
            end else begin
                run_cycle(dv, next_seq, 0, 0, kv, ki, bit'($urandom % 4 != 0), wv, wi);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule